// File: doc/BRIEF.md
# Byte-Staged PLL Mode Register Loader

This block sits behind a 16-bit write port through which software builds PLL settings one byte at a time. Every write carries a data byte, a register selector and a commit strobe bit. A byte only lands in its target register after two writes: the first with the strobe bit clear, the second with it set. The rising strobe is the commit. This keeps a single stray write from changing a PLL setting.

Four 8-bit registers sit behind the selector: the low and high halves of the core PLL mode word, a core PLL configuration byte, and a DAC PLL configuration byte. The low half is only staged when it commits. The applied mode word moves only when the high half commits. At that point the block takes the new high byte together with the staged low byte, then raises a single-cycle update pulse. A half-written word therefore never reaches the PLL. The applied word is also presented as unpacked divider fields, both as raw codes and as the actual divider values. The last control value written can be read back at any time.

Top module: `pll_mode_loader`

## Requirements
- R1: A write with `wr_en` high is decoded as follows. The data byte is in bits 7:0. The selector is in bits 9:8. The commit strobe is bit 14. Bits 13:10 and bit 15 have no effect on any register.
- R2: The selector picks the target register. Value 3 is mode word bits 7:0, value 2 is mode word bits 15:8, value 1 is the core configuration byte, and value 0 is the DAC configuration byte.
- R3: A commit happens on an enabled write under two conditions: its strobe bit is 1 while the strobe bit of the previous enabled write was 0, and its selector equals the previous write's selector. A commit loads this write's byte at the same clock edge. The state after reset counts as a previous write of 0x0000.
- R4: An enabled write with the strobe set but a selector different from the previous write changes no register. So does a write whose strobe was already set in the previous write.
- R5: A high-byte commit loads `mode_word` with {new high byte, staged low byte} at its clock edge. `pll_update` is then high for exactly the following cycle. `mode_word` changes at no other time except reset.
- R6: `post_div` is mode_word[1:0]. `fb_div_code` is mode_word[10:2] and `fb_div` equals that code plus 2. `ref_div_code` is mode_word[15:11] and `ref_div` equals that code plus 2.
- R7: Reset (`rst_n` low, asynchronous) clears all four registers, the applied word, `pll_update`, the strobe history and `rd_data` to zero.
- R8: `rd_data` returns, from the clock edge after an enabled write, the full 16-bit value of that write.
- R9: A low-byte commit does not alter `mode_word`, its fields or `pll_update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the control port |
| wr_data | input | 16 | Control value: byte, selector, strobe |
| rd_data | output | 16 | Last control value written |
| dac_cfg | output | 8 | DAC PLL configuration byte |
| core_cfg | output | 8 | Core PLL configuration byte |
| mode_word | output | 16 | Applied core PLL mode word |
| post_div | output | 2 | Post-divider field |
| fb_div_code | output | 9 | Feedback divider code (divider minus 2) |
| ref_div_code | output | 5 | Reference divider code (divider minus 2) |
| fb_div | output | 10 | Feedback divider value |
| ref_div | output | 6 | Reference divider value |
| pll_update | output | 1 | One-cycle pulse after a new mode word is applied |

## Verification
The assertions assume two things about the inputs: `wr_data` is stable at each rising edge, and reset only holds the block in its cleared state. Under those assumptions, every register change can be traced to a single commit, and two commits can never come on back-to-back cycles. The stimulus changes inputs only on falling edges. It mixes proper clear-then-set pairs with several kinds of writes: wrong-selector strobes, repeated strobes, disabled cycles with garbage data, and noise in the unused bits. A mid-run reset checks that the strobe history is cleared along with the registers.

// File: rtl/pml_pkg.sv
package pml_pkg;
  localparam int CTRL_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int SEL_LSB  = 8;
  localparam int SEL_W    = 2;
  localparam int STB_BIT  = 14;
  localparam int NUM_REGS = 1 << SEL_W;
  localparam int POST_W   = 2;
  localparam int FB_W     = 9;
  localparam int REF_W    = 5;
  localparam int DIV_OFS  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DAC = 2'd0,
    SEL_CFG = 2'd1,
    SEL_HI  = 2'd2,
    SEL_LO  = 2'd3
  } sel_e;

  typedef struct packed {
    logic [REF_W-1:0]  ref_code;
    logic [FB_W-1:0]   fb_code;
    logic [POST_W-1:0] post;
  } mode_word_t;

  function automatic logic [SEL_W-1:0] ctrl_sel(input logic [CTRL_W-1:0] v);
    return v[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic ctrl_strobe(input logic [CTRL_W-1:0] v);
    return v[STB_BIT];
  endfunction

  function automatic logic [BYTE_W-1:0] ctrl_byte(input logic [CTRL_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction

  function automatic logic [FB_W:0] fb_actual(input logic [FB_W-1:0] code);
    return {1'b0, code} + (FB_W+1)'(DIV_OFS);
  endfunction

  function automatic logic [REF_W:0] ref_actual(input logic [REF_W-1:0] code);
    return {1'b0, code} + (REF_W+1)'(DIV_OFS);
  endfunction
endpackage

// File: rtl/pml_strobe_detect.sv
module pml_strobe_detect
  import pml_pkg::*;
#(
  parameter int CW   = CTRL_W,
  parameter int SW   = SEL_W,
  parameter int SLSB = SEL_LSB,
  parameter int SBIT = STB_BIT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] last_ctrl,
  output logic          commit,
  output logic [SW-1:0] commit_sel
);
  logic          stb_now, stb_prev, sel_match;
  logic [SW-1:0] sel_now;

  assign sel_now    = wr_data[SLSB +: SW];
  assign stb_now    = wr_data[SBIT];
  assign stb_prev   = last_ctrl[SBIT];
  assign sel_match  = (sel_now == last_ctrl[SLSB +: SW]);
  assign commit     = wr_en && stb_now && !stb_prev && sel_match;
  assign commit_sel = sel_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     last_ctrl <= '0;
    else if (wr_en) last_ctrl <= wr_data;
  end

  // R4: after a commit the history holds the strobe set, so no second one follows
  a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  // R8: readback follows the enabled write
  a_r8_history_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> last_ctrl == $past(wr_data));
endmodule

// File: rtl/pml_byte_bank.sv
module pml_byte_bank
  import pml_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int SW = SEL_W,
  parameter int NR = NUM_REGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [SW-1:0]        commit_sel,
  input  logic [BW-1:0]        commit_byte,
  output logic [NR-1:0][BW-1:0] regs_q
);
  for (genvar gi = 0; gi < NR; gi++) begin : g_reg
    logic hit;
    assign hit = commit && (commit_sel == SW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[gi] <= '0;
      else if (hit) regs_q[gi] <= commit_byte;
    end

    // R3: a register moves only at a commit addressed to it
    a_r3_change_needs_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(regs_q[gi]) |-> $past(commit) && ($past(commit_sel) == SW'(gi)));
    // R2: the committed byte lands in the addressed slot
    a_r2_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && commit_sel == SW'(gi)) |=> regs_q[gi] == $past(commit_byte));
  end
endmodule

// File: rtl/pml_word_apply.sv
module pml_word_apply
  import pml_pkg::*;
#(
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit_hi,
  input  logic [BW-1:0] hi_byte,
  input  logic [BW-1:0] lo_staged,
  output logic [WW-1:0] word_q,
  output logic          upd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= commit_hi;
      if (commit_hi) word_q <= {hi_byte, lo_staged};
    end
  end

  // R5: the update pulse lasts one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);
  // R5: the applied word only moves together with the pulse
  a_r5_word_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> upd_q);
endmodule

// File: rtl/pll_mode_loader.sv
module pll_mode_loader
  import pml_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int BW = BYTE_W,
  localparam int WW = 2 * BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     rd_data,
  output logic [BW-1:0]     dac_cfg,
  output logic [BW-1:0]     core_cfg,
  output logic [WW-1:0]     mode_word,
  output logic [POST_W-1:0] post_div,
  output logic [FB_W-1:0]   fb_div_code,
  output logic [REF_W-1:0]  ref_div_code,
  output logic [FB_W:0]     fb_div,
  output logic [REF_W:0]    ref_div,
  output logic              pll_update
);
  logic                        commit;
  logic [SEL_W-1:0]            commit_sel;
  logic [NUM_REGS-1:0][BW-1:0] regs_q;
  logic                        commit_hi;
  logic                        commit_lo;
  mode_word_t                  fields;

  pml_strobe_detect u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .last_ctrl  (rd_data),
    .commit     (commit),
    .commit_sel (commit_sel)
  );

  pml_byte_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_sel  (commit_sel),
    .commit_byte (ctrl_byte(wr_data)),
    .regs_q      (regs_q)
  );

  assign commit_hi = commit && (commit_sel == SEL_HI);
  assign commit_lo = commit && (commit_sel == SEL_LO);

  pml_word_apply u_apply (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_hi (commit_hi),
    .hi_byte   (ctrl_byte(wr_data)),
    .lo_staged (regs_q[SEL_LO]),
    .word_q    (mode_word),
    .upd_q     (pll_update)
  );

  assign dac_cfg      = regs_q[SEL_DAC];
  assign core_cfg     = regs_q[SEL_CFG];
  assign fields       = mode_word_t'(mode_word);
  assign post_div     = fields.post;
  assign fb_div_code  = fields.fb_code;
  assign ref_div_code = fields.ref_code;
  assign fb_div       = fb_actual(fields.fb_code);
  assign ref_div      = ref_actual(fields.ref_code);

  // R9: a low-byte commit leaves the applied word alone
  a_r9_lo_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    commit_lo |=> $stable(mode_word) && !pll_update);
  // R5: the applied high byte equals the byte just committed
  a_r5_hi_byte_applied: assert property (@(posedge clk) disable iff (!rst_n)
    commit_hi |=> mode_word[WW-1:BW] == regs_q[SEL_HI]);
  // R4: a strobe write with a foreign selector leaves all registers alone
  a_r4_foreign_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[STB_BIT] && (ctrl_sel(wr_data) != ctrl_sel(rd_data)))
      |=> $stable(regs_q) && $stable(mode_word));
endmodule

// File: tb/pll_mode_loader_tb.sv
module pll_mode_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [7:0]  dac_cfg, core_cfg;
  logic [15:0] mode_word;
  logic [1:0]  post_div;
  logic [8:0]  fb_div_code;
  logic [4:0]  ref_div_code;
  logic [9:0]  fb_div;
  logic [5:0]  ref_div;
  logic        pll_update;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pll_mode_loader u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dac_cfg(dac_cfg), .core_cfg(core_cfg),
    .mode_word(mode_word), .post_div(post_div), .fb_div_code(fb_div_code),
    .ref_div_code(ref_div_code), .fb_div(fb_div), .ref_div(ref_div),
    .pll_update(pll_update)
  );

  // Behavioural reference model
  int m_last = 0;
  int m_reg[4] = '{0, 0, 0, 0};
  int m_word = 0;
  int m_upd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 0; m_word = 0; m_upd = 0;
      foreach (m_reg[k]) m_reg[k] = 0;
    end else begin
      int d, sel, psel, stb, pstb;
      m_upd = 0;
      if (wr_en) begin
        d = int'(wr_data);
        sel = (d / 256) % 4;   psel = (m_last / 256) % 4;
        stb = (d / 16384) % 2; pstb = (m_last / 16384) % 2;
        if (stb == 1 && pstb == 0 && sel == psel) begin
          m_reg[sel] = d % 256;
          if (sel == 2) begin
            m_word = (d % 256) * 256 + m_reg[3];
            m_upd = 1;
          end
        end
        m_last = d;
      end
    end
  end

  task automatic cmp(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R8 rd_data", int'(rd_data), m_last);
    cmp("R2 dac_cfg", int'(dac_cfg), m_reg[0]);
    cmp("R2 core_cfg", int'(core_cfg), m_reg[1]);
    cmp("R5 mode_word", int'(mode_word), m_word);
    cmp("R5 pll_update", int'(pll_update), m_upd);
    cmp("R6 post_div", int'(post_div), m_word % 4);
    cmp("R6 fb_div_code", int'(fb_div_code), (m_word / 4) % 512);
    cmp("R6 ref_div_code", int'(ref_div_code), m_word / 2048);
    cmp("R6 fb_div", int'(fb_div), (m_word / 4) % 512 + 2);
    cmp("R6 ref_div", int'(ref_div), m_word / 2048 + 2);
  endtask

  task automatic step(input logic en, input logic [15:0] d);
    @(negedge clk);
    compare_all();
    wr_en = en; wr_data = d;
  endtask

  task automatic put_byte(input int sel, input logic [7:0] b);
    step(1'b1, {2'b00, 4'b0000, sel[1:0], b});
    step(1'b1, {2'b01, 4'b0000, sel[1:0], b});
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7: reset state
    @(negedge clk);
    cmp("R7 reset rd_data", int'(rd_data), 0);
    cmp("R7 reset mode_word", int'(mode_word), 0);
    cmp("R7 reset pll_update", int'(pll_update), 0);

    // R2/R6/R9: low byte staged, then high byte applies the word 0xA5C3
    put_byte(3, 8'hC3);
    step(1'b0, 16'h0000);
    cmp("R9 lo commit keeps word", int'(mode_word), 0);
    put_byte(2, 8'hA5);
    step(1'b0, 16'h0000);
    cmp("R5 update pulse", int'(pll_update), 1);
    cmp("R6 word", int'(mode_word), 16'hA5C3);
    cmp("R6 post_div", int'(post_div), 3);
    cmp("R6 fb_div", int'(fb_div), 370);
    cmp("R6 ref_div", int'(ref_div), 22);
    step(1'b0, 16'h0000);
    cmp("R5 pulse ends", int'(pll_update), 0);

    // R4: strobe set with a different selector
    step(1'b1, 16'h0033);                 // sel 0, strobe clear
    step(1'b1, 16'h4133);                 // sel 1, strobe set -> ignored
    step(1'b0, 16'h0000);
    cmp("R4 foreign selector", int'(core_cfg), 0);
    // R4: repeated strobe does not commit again
    put_byte(1, 8'h5A);
    step(1'b1, 16'h4177);
    step(1'b0, 16'h0000);
    cmp("R4 repeated strobe", int'(core_cfg), 8'h5A);
    // R1: noise in bits 13:10 and 15 is harmless
    step(1'b1, 16'hBC00 & 16'hBFFF | 16'h0011);
    step(1'b1, 16'hFC11);
    step(1'b0, 16'h0000);
    cmp("R1 noise bits", int'(dac_cfg), 8'h11);
    cmp("R8 full readback", int'(rd_data), 16'hFC11);

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      if (r < 5)       put_byte($urandom_range(0, 3), d[7:0]);
      else if (r == 5) step(1'b0, d);
      else             step(1'b1, d);
      if (i == 2000) begin
        @(negedge clk);
        compare_all();
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        cmp("R7 mid reset word", int'(mode_word), 0);
        cmp("R7 mid reset rd", int'(rd_data), 0);
        rst_n = 1'b1;
        // R3: history of 0x0000 after reset lets a lone strobe on sel 0 commit
        step(1'b1, 16'h40AB);
        step(1'b0, 16'h0000);
        cmp("R3 post-reset commit", int'(dac_cfg), 8'hAB);
      end
    end
    step(1'b0, 16'h0000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule